// File: doc/BRIEF.md
# Four-Channel Input Capture Unit

This block watches four asynchronous input pins and, when a pin shows the transition its channel is set up for, stores the value of a free-running timer count in that channel's 16-bit capture register. It also raises a sticky per-channel flag. Each channel has a 2-bit edge selector in a shared 8-bit control register. The selector can choose off, rising only, falling only or either edge. The channels run independently of each other.

The fourth channel's register has two roles. When the role input is high, it is a capture register like the others, and bus writes to it are dropped. When the role input is low, it becomes a plain read/write compare register that captures never disturb.

Software reaches the block through a small synchronous register bus. Address 0 holds the edge control. Address 1 holds the flags, which are cleared by writing 1. Addresses 2 to 5 hold the capture registers for channels 1 to 4.

Top module: `input_capture_unit`

## Requirements
- R1: After a synchronous reset, the control register, all flags and all four capture registers read 0.
- R2: A channel's selector code means: 00 no capture, 01 rising edges only, 10 falling edges only, 11 both edges.
- R3: The control register at address 0 places channel 4's selector in bits 7:6, channel 1's in 5:4, channel 2's in 3:2 and channel 3's in 1:0, and reads back as written.
- R4: Each pin passes through a two-stage synchronizer. A qualifying transition that the pin shows before rising clock edge E1 sets the flag, and stores the timer count present at that edge, at edge E3. The flag is still clear after edge E2.
- R5: The flags (address 1, bit n-1 for channel n) stay set until a bus write with a 1 in that bit clears them. Zero bits leave flags alone. If a set and a clear land in the same cycle, the set wins.
- R6: Channel 4 captures and flags only while `last_ch_capture_mode` is 1.
- R7: While `last_ch_capture_mode` is 1, bus writes to address 5 have no effect. While it is 0, address 5 is written by the bus and reads back the written value.
- R8: Channels that see qualifying transitions in the same cycle all store the same count.
- R9: Setting a selector to 00 stops further captures on that channel and keeps the value it last stored.
- R10: Read data appears on `bus_rdata` one clock after the address is presented. Bus writes to addresses 2 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tmr_count | input | 16 | Free-running timer count |
| cap_pin | input | 4 | Asynchronous capture pins, bit n-1 is channel n |
| last_ch_capture_mode | input | 1 | 1: channel 4 captures, 0: its register is a compare register |
| cap_flag | output | 4 | Sticky capture flags |

## Verification
The hardest case to reach from the ports is a flag clear arriving in the very cycle a capture sets the same flag. The bench lines this up by counting synchronizer stages from the falling edge where it drives the pin. It asserts the clearing write for exactly the cycle that ends at the third rising edge, and it also confirms that the flag is still low one edge earlier. A stimulus table sweeps all four selector codes against changing pin patterns. Directed steps then flip the fourth channel's role and try writes in both roles.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_FLAG = 1;
  localparam int unsigned ADDR_CAP0 = 2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // last channel sits in the top pair, the others follow downward from channel 0
  function automatic int unsigned sel_lsb(input int unsigned ch, input int unsigned nch);
    return 2 * ((ch == nch - 1) ? (nch - 1) : (nch - 2 - ch));
  endfunction
endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter bit          SHARED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  edge_sel_e        sel,
  input  logic             rise,
  input  logic             fall,
  input  logic             cap_enable,
  input  logic [CNT_W-1:0] count,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] wdata,
  output logic             hit,
  output logic [CNT_W-1:0] cap_q
);
  logic qual;

  always_comb begin
    unique case (sel)
      EDGE_RISE: qual = rise;
      EDGE_FALL: qual = fall;
      EDGE_ANY:  qual = rise | fall;
      default:   qual = 1'b0;
    endcase
  end

  assign hit = qual & cap_enable;

  generate
    if (SHARED) begin : g_shared
      always_ff @(posedge clk) begin
        if (rst)                         cap_q <= '0;
        else if (hit)                    cap_q <= count;
        else if (wr_load && !cap_enable) cap_q <= wdata;
      end
    end else begin : g_capture_only
      logic unused_ok;
      assign unused_ok = wr_load ^ (^wdata);
      always_ff @(posedge clk) begin
        if (rst)      cap_q <= '0;
        else if (hit) cap_q <= count;
      end
    end
  endgenerate
endmodule

// File: rtl/input_capture_unit.sv
module input_capture_unit
  import icap_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  tmr_count,
  input  logic [NCH-1:0]    cap_pin,
  input  logic              last_ch_capture_mode,
  output logic [NCH-1:0]    cap_flag
);
  localparam int unsigned CTRL_W = 2 * NCH;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]    flag_q;
  logic [NCH-1:0]    cap_hit;
  logic [NCH-1:0]    flag_clr;
  logic [CNT_W-1:0]  cap_q [NCH];
  logic [CNT_W-1:0]  rd_mux;

  wire ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
  wire flag_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAG));

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int unsigned LSB = sel_lsb(ch, NCH);
      logic rise, fall;

      icap_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin_async(cap_pin[ch]), .rise(rise), .fall(fall)
      );

      icap_channel #(.CNT_W(CNT_W), .SHARED(ch == NCH - 1)) chan_i (
        .clk(clk),
        .rst(rst),
        .sel(edge_sel_e'(ctrl_q[LSB +: 2])),
        .rise(rise),
        .fall(fall),
        .cap_enable((ch == NCH - 1) ? last_ch_capture_mode : 1'b1),
        .count(tmr_count),
        .wr_load(bus_wr && (bus_addr == ADDR_W'(ADDR_CAP0 + ch))),
        .wdata(bus_wdata),
        .hit(cap_hit[ch]),
        .cap_q(cap_q[ch])
      );
    end
  endgenerate

  assign flag_clr = flag_wr ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
      flag_q <= (flag_q & ~flag_clr) | cap_hit;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) rd_mux = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(ADDR_FLAG)) rd_mux = CNT_W'(flag_q);
    for (int ch = 0; ch < NCH; ch++)
      if (bus_addr == ADDR_W'(ADDR_CAP0 + ch)) rd_mux = cap_q[ch];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign cap_flag = flag_q;
endmodule

// File: rtl/icap_checker.sv
module icap_checker
  import icap_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              role,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    cap_flag,
  input logic [NCH-1:0]    hit,
  input logic [2*NCH-1:0]  ctrl,
  input logic [CNT_W-1:0]  cap_first,
  input logic [CNT_W-1:0]  cap_second,
  input logic [CNT_W-1:0]  cap_last
);
  localparam int unsigned L0 = sel_lsb(0, NCH);

  AST_RESET_CLEARS_FLAGS: assert property (@(posedge clk) rst |=> cap_flag == '0); // R1

  AST_LAST_NEEDS_ROLE: assert property (@(posedge clk) disable iff (rst)
    !role |=> !$rose(cap_flag[NCH-1])); // R6

  AST_LAST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (role && bus_wr && bus_addr == ADDR_W'(ADDR_CAP0 + NCH - 1) && !hit[NCH-1]) |=> $stable(cap_last)); // R7

  AST_SAME_CYCLE_SAME_VALUE: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && hit[1]) |=> cap_first == cap_second); // R8

  AST_OFF_KEEPS_VALUE: assert property (@(posedge clk) disable iff (rst)
    (ctrl[L0 +: 2] == 2'b00) |=> $stable(cap_first)); // R9

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_flag
      AST_FLAG_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        !hit[ch] |=> !$rose(cap_flag[ch])); // R5
    end
  endgenerate
endmodule

bind input_capture_unit icap_checker #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .role(last_ch_capture_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cap_flag(cap_flag), .hit(cap_hit), .ctrl(ctrl_q),
  .cap_first(cap_q[0]), .cap_second(cap_q[1]), .cap_last(cap_q[NCH-1])
);

// File: tb/input_capture_unit_tb.sv
`timescale 1ns/1ps
module input_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] tmr_count = '0;
  logic [3:0]  cap_pin = '0;
  logic        role = 1'b1;
  logic [3:0]  cap_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [15:0] exp_cap [4];
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  input_capture_unit dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_count(tmr_count), .cap_pin(cap_pin),
    .last_ch_capture_mode(role), .cap_flag(cap_flag)
  );

  // {ctrl[7:0], new pins[3:0], expected flags[3:0], count[15:0]}
  localparam logic [31:0] VEC [9] = '{
    32'h55FF1234,  // R2 rising on all: 0000->1111
    32'h55002000,  // R2 falling ignored by rising-only
    32'hAA503000,  // R2 rising ignored by falling-only
    32'hAA054444,  // R2 falling captured, R8 two channels same count
    32'hFFAA5555,  // R2 both edges
    32'h00506666,  // R9 all off, values kept
    32'h30A17777,  // R3 only channel 1 field set
    32'h42508888,  // R3 ch4 rising + ch3 falling, wrong directions
    32'h42AC9999   // R3 ch4 and ch3 fire
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(16'(cap_flag), 16'h0, "R1 flags");
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv);
      check(rv, 16'h0, "R1 register");
    end
    for (int c = 0; c < 4; c++) exp_cap[c] = '0;

    for (int v = 0; v < 9; v++) begin
      wr(3'd1, 16'h000F);
      wr(3'd0, {8'h00, VEC[v][31:24]});
      tmr_count = VEC[v][15:0];
      cap_pin = VEC[v][23:20];
      repeat (4) @(negedge clk);
      check(16'(cap_flag), 16'(VEC[v][19:16]), "R2/R3 flags");
      for (int c = 0; c < 4; c++) begin
        if (VEC[v][16 + c]) exp_cap[c] = VEC[v][15:0];
        rd(3'(2 + c), rv);
        check(rv, exp_cap[c], "R4/R8/R9 capture");
      end
    end

    // R5 write-1-clear, zero bits leave flags
    wr(3'd1, 16'h0004);
    check(16'(cap_flag), 16'h0008, "R5 partial clear");
    wr(3'd1, 16'h0000);
    check(16'(cap_flag), 16'h0008, "R5 zero write");

    // R3 readback
    rd(3'd0, rv);
    check(rv, 16'h0042, "R3 ctrl readback");

    // R7 writes dropped in capture role, accepted in compare role
    wr(3'd5, 16'hBEEF);
    rd(3'd5, rv);
    check(rv, exp_cap[3], "R7 write ignored");
    role = 1'b0;
    wr(3'd5, 16'hBEEF);
    rd(3'd5, rv);
    check(rv, 16'hBEEF, "R7 compare write");

    // R6 no capture on channel 4 in compare role
    wr(3'd1, 16'h000F);
    wr(3'd0, 16'h00C0);
    tmr_count = 16'hAAAA;
    cap_pin = 4'b0010;
    repeat (4) @(negedge clk);
    check(16'(cap_flag[3]), 16'h0, "R6 flag");
    rd(3'd5, rv);
    check(rv, 16'hBEEF, "R6 value held");

    // R10 capture-only registers ignore writes
    wr(3'd2, 16'h1111);
    rd(3'd2, rv);
    check(rv, exp_cap[0], "R10 read-only");

    // R5 set beats same-cycle clear, R4 latency
    role = 1'b1;
    wr(3'd0, 16'h0010);
    wr(3'd1, 16'h000F);
    tmr_count = 16'hC0DE;
    cap_pin = 4'b0011;          // before E1
    @(negedge clk);             // after E1
    @(negedge clk);             // after E2
    check(16'(cap_flag[0]), 16'h0, "R4 not yet");
    bus_addr = 3'd1; bus_wdata = 16'h0001; bus_wr = 1'b1;
    @(negedge clk);             // after E3
    bus_wr = 1'b0;
    check(16'(cap_flag[0]), 16'h1, "R5 set wins");
    rd(3'd2, rv);
    check(rv, 16'hC0DE, "R4 count at E3");

    summary();
  end
endmodule